// File: doc/BRIEF.md
# Complementary PWM Timer Channel

This block is one channel of a motor-drive PWM timer. It produces two complementary outputs, A and B. Its counter runs against a period register. It compares the count with a pulse-width register to decide when A is active, and B takes the opposite state. The counter has two modes. It can count up and wrap (edge mode), or count up and back down (center mode). Both outputs can be inverted together. Optional dead time holds off each passive-to-active change so that the two outputs never conduct at the same time.

Software reaches the channel through a small write port. The control word can be read at any time on a dedicated output. It can only be changed through a set port and a clear port, so one field can be modified without a read-modify-write. Period, width and dead time are first written to staging registers. These are copied into the working registers at the end of each PWM cycle, unless the freeze bit blocks the copy. While the channel is halted, the working registers track the staging registers directly. A one-cycle pulse marks every cycle end.

Top module: `mc_pwm_channel`

## Requirements
- R1: After reset the control word reads 0, both outputs are low and the cycle-end pulse is low.
- R2: The port address selects the target: 0 set, 1 clear, 2 period, 3 width, 4 dead time. Each 1 in a set write sets the matching control bit, and each 1 in a clear write clears it. Each 0 leaves its bit unchanged. Control bits are: bit 0 run, bit 1 center mode, bit 2 invert, bit 3 dead-time enable, bit 4 freeze. Bits 7:5 always read 0.
- R3: While run is 0, both outputs sit at the passive level (equal to the invert bit) and no cycle-end pulse is produced.
- R4: Edge mode. In the t-th cycle after the edge that sets run, the count is t mod (P+1), where P is the period. The cycle-end pulse is high when the count equals P.
- R5: Center mode (P at least 1). The count follows p = t mod 2P: it is p when p is at most P, and 2P-p otherwise. The cycle-end pulse is high when p is 0 and t is above 0.
- R6: Before dead time and inversion, A is active while running and the count is at or above the width. B is active while running and A is not.
- R7: Each output pin equals its active state XOR the invert bit.
- R8: With dead time D enabled, an output becomes active only once its pre-dead-time state has been active for D+1 consecutive cycles. It goes passive at once. A and B are never active together.
- R9: With freeze at 0, a new period written while running takes effect only after the next cycle end.
- R10: With freeze at 1, working registers do not change while running.
- R11: While halted, the working registers follow the staging registers, so values written before a start apply from the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write target (0 set, 1 clear, 2 period, 3 width, 4 dead time) |
| wr_data | input | CNT_W | Write data |
| ctrl_rd | output | 8 | Current control word |
| pwm_a | output | 1 | Output A pin level |
| pwm_b | output | 1 | Output B pin level |
| cyc_end | output | 1 | One-cycle end-of-cycle pulse |

## Verification
The hardest case to reach from the ports is a staging write that lands in the middle of a running cycle. The working copy must then be loaded at exactly the next cycle end, or not at all when frozen. The counter is not a port, so the stimulus starts the channel at a known cycle and writes the period a fixed number of cycles later. It then measures the spacing of the cycle-end pulses, which must show the old period once before the new one, or the old period throughout when frozen. Dead-time behaviour is reached by sweeping every width from 0 to above the period, in both counting modes and both polarities. This walks each output through short, long and absent active phases.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;
  localparam int CTRL_W = 8;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 8'h1F;

  typedef struct packed {
    logic frz;
    logic dten;
    logic inv;
    logic ctr;
    logic run;
  } pwm_ctrl_t;

  typedef enum logic [2:0] {
    A_SET = 3'd0,
    A_CLR = 3'd1,
    A_PER = 3'd2,
    A_WID = 3'd3,
    A_DT  = 3'd4
  } pwm_addr_e;

  function automatic logic pin_level(input logic act, input logic inv);
    return act ^ inv;
  endfunction
endpackage

// File: rtl/pwm_ctrl_bits.sv
module pwm_ctrl_bits
  import mcpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [CTRL_W-1:0] bits,
  output logic [CTRL_W-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      word_q <= '0;
    else if (set_we) word_q <= (word_q | bits) & CTRL_MASK;
    else if (clr_we) word_q <= (word_q & ~bits) & CTRL_MASK;
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             center,
  input  logic             frz,
  input  logic [CNT_W-1:0] per_wr,
  input  logic [CNT_W-1:0] wid_wr,
  input  logic [CNT_W-1:0] dt_wr,
  output logic [CNT_W-1:0] cnt,
  output logic             cyc_end,
  output logic             load,
  output logic [CNT_W-1:0] per_w,
  output logic [CNT_W-1:0] wid_w,
  output logic [CNT_W-1:0] dt_w
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             dn;
  logic [CNT_W-1:0] per_nxt;

  function automatic logic [CNT_W-1:0] edge_step(input logic [CNT_W-1:0] c,
                                                 input logic [CNT_W-1:0] p);
    return (c >= p) ? '0 : c + ONE;
  endfunction

  function automatic logic [CNT_W-1:0] turn_down(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - ONE;
  endfunction

  function automatic logic [CNT_W-1:0] turn_up(input logic [CNT_W-1:0] p);
    return (p == '0) ? '0 : ONE;
  endfunction

  always_comb begin
    cyc_end = run & (center ? (dn & (cnt == '0)) : (cnt >= per_w));
    load    = ~run | (cyc_end & ~frz);
    per_nxt = load ? per_wr : per_w;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      dn    <= 1'b0;
      per_w <= '0;
      wid_w <= '0;
      dt_w  <= '0;
    end else begin
      if (load) begin
        per_w <= per_wr;
        wid_w <= wid_wr;
        dt_w  <= dt_wr;
      end
      if (!run) begin
        cnt <= '0;
        dn  <= 1'b0;
      end else if (!center) begin
        cnt <= edge_step(cnt, per_w);
        dn  <= 1'b0;
      end else if (!dn) begin
        if (cnt >= per_w) begin
          dn  <= 1'b1;
          cnt <= turn_down(cnt);
        end else begin
          cnt <= cnt + ONE;
        end
      end else if (cnt == '0) begin
        dn  <= 1'b0;
        cnt <= turn_up(per_nxt);
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] dt,
  input  logic             raw,
  output logic             act
);
  logic [CNT_W-1:0] hold;

  assign act = raw & (~en | (hold >= dt));

  always_ff @(posedge clk) begin
    if (!rst_n)        hold <= '0;
    else if (!raw)     hold <= '0;
    else if (hold < dt) hold <= hold + CNT_W'(1);
  end
endmodule

// File: rtl/mc_pwm_channel.sv
module mc_pwm_channel
  import mcpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [7:0]       ctrl_rd,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             cyc_end
);
  localparam int NOUT = 2;

  logic [CTRL_W-1:0] word_q;
  pwm_ctrl_t         ctl;
  logic [CNT_W-1:0]  per_wr, wid_wr, dt_wr;
  logic [CNT_W-1:0]  cnt, per_w, wid_w, dt_w;
  logic              load;
  logic              run_w, inv_w, frz_w, dten_w;
  logic              above;
  logic [NOUT-1:0]   raw_v, act_v;

  pwm_ctrl_bits u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (wr_en && (wr_addr == A_SET)),
    .clr_we (wr_en && (wr_addr == A_CLR)),
    .bits   (wr_data[CTRL_W-1:0]),
    .word_q (word_q)
  );

  assign ctl     = pwm_ctrl_t'(word_q[4:0]);
  assign ctrl_rd = word_q;
  assign run_w   = ctl.run;
  assign inv_w   = ctl.inv;
  assign frz_w   = ctl.frz;
  assign dten_w  = ctl.dten;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_wr <= '0;
      wid_wr <= '0;
      dt_wr  <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_PER) per_wr <= wr_data;
      if (wr_addr == A_WID) wid_wr <= wr_data;
      if (wr_addr == A_DT)  dt_wr  <= wr_data;
    end
  end

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_w),
    .center  (ctl.ctr),
    .frz     (frz_w),
    .per_wr  (per_wr),
    .wid_wr  (wid_wr),
    .dt_wr   (dt_wr),
    .cnt     (cnt),
    .cyc_end (cyc_end),
    .load    (load),
    .per_w   (per_w),
    .wid_w   (wid_w),
    .dt_w    (dt_w)
  );

  assign above    = cnt >= wid_w;
  assign raw_v[0] = run_w & above;
  assign raw_v[1] = run_w & ~above;

  for (genvar g = 0; g < NOUT; g++) begin : g_db
    pwm_deadband #(.CNT_W(CNT_W)) u_db (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (dten_w),
      .dt    (dt_w),
      .raw   (raw_v[g]),
      .act   (act_v[g])
    );
  end

  assign pwm_a = pin_level(act_v[0], inv_w);
  assign pwm_b = pin_level(act_v[1], inv_w);
endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       ctrl_rd,
  input logic             run,
  input logic             inv,
  input logic             frz,
  input logic             pwm_a,
  input logic             pwm_b,
  input logic             cyc_end,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per_w,
  input logic [CNT_W-1:0] wid_w,
  input logic [CNT_W-1:0] dt_w
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[7:5] == 3'b000);

  assert_halted_passive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pwm_a == inv && pwm_b == inv && !cyc_end));

  assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= per_w);

  assert_end_when_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |-> run);

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !((pwm_a ^ inv) && (pwm_b ^ inv)));

  assert_load_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(per_w) |-> $past(!run || cyc_end));

  assert_frozen_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && frz) |=> ($stable(per_w) && $stable(wid_w) && $stable(dt_w)));
endmodule

bind mc_pwm_channel pwm_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ctrl_rd (ctrl_rd),
  .run     (run_w),
  .inv     (inv_w),
  .frz     (frz_w),
  .pwm_a   (pwm_a),
  .pwm_b   (pwm_b),
  .cyc_end (cyc_end),
  .cnt     (cnt),
  .per_w   (per_w),
  .wid_w   (wid_w),
  .dt_w    (dt_w)
);

// File: tb/test_mc_pwm_channel.sv
`timescale 1ns/1ps
module test_mc_pwm_channel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] ctrl_rd;
  logic       pwm_a, pwm_b, cyc_end;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  mc_pwm_channel #(.CNT_W(8)) i_mc_pwm_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_rd(ctrl_rd), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .cyc_end(cyc_end)
  );

  initial forever #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 3'd0; wr_data = 8'd0;
  endtask

  function automatic int exp_count(input bit ctr, input int p, input int t);
    int ph;
    if (!ctr) return t % (p + 1);
    ph = t % (2 * p);
    return (ph <= p) ? ph : 2 * p - ph;
  endfunction

  function automatic bit exp_end(input bit ctr, input int p, input int t);
    if (!ctr) return (t % (p + 1)) == p;
    return (t > 0) && ((t % (2 * p)) == 0);
  endfunction

  task automatic run_config(input bit ctr, input bit inv, input bit dte,
                            input int dt, input int p, input int w);
    int ra_len = 0;
    int rb_len = 0;
    int len;
    bit ra, rb, aa, ab;
    reg_wr(3'd1, 8'hFF);
    reg_wr(3'd2, 8'(p));
    reg_wr(3'd3, 8'(w));
    reg_wr(3'd4, 8'(dt));
    reg_wr(3'd0, {4'b0, dte, inv, ctr, 1'b0});
    check("R3 R7 halted", int'({pwm_a, pwm_b, cyc_end}), int'({inv, inv, 1'b0}));
    reg_wr(3'd0, 8'h01);
    len = ctr ? 2 * p : p + 1;
    for (int t = 0; t < 2 * len + 2; t++) begin
      ra = exp_count(ctr, p, t) >= w;
      rb = !ra;
      ra_len = ra ? ra_len + 1 : 0;
      rb_len = rb ? rb_len + 1 : 0;
      aa = ra && (!dte || ra_len >= dt + 1);
      ab = rb && (!dte || rb_len >= dt + 1);
      check(ctr ? "R5 R6 R7 R8" : "R4 R6 R7 R8", int'({pwm_a, pwm_b, cyc_end}),
            int'({aa ^ inv, ab ^ inv, exp_end(ctr, p, t)}));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ctrl", int'(ctrl_rd), 0);
    check("R1 outputs", int'({pwm_a, pwm_b, cyc_end}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'({ctrl_rd, pwm_a, pwm_b}), 0);

    // R2: set/clear access, reserved bits
    reg_wr(3'd0, 8'hFF); check("R2 set", int'(ctrl_rd), 'h1F);
    reg_wr(3'd1, 8'h15); check("R2 clear", int'(ctrl_rd), 'h0A);
    reg_wr(3'd0, 8'h00); check("R2 set zero", int'(ctrl_rd), 'h0A);
    reg_wr(3'd1, 8'h00); check("R2 clear zero", int'(ctrl_rd), 'h0A);
    reg_wr(3'd0, 8'hE0); check("R2 reserved", int'(ctrl_rd), 'h0A);
    reg_wr(3'd1, 8'hFF); check("R2 clear all", int'(ctrl_rd), 0);

    // Sweep of modes, polarity, dead time, period and width
    for (int ctr = 0; ctr < 2; ctr++)
      for (int inv = 0; inv < 2; inv++)
        for (int dm = 0; dm < 3; dm++)
          for (int p = 1; p <= 4; p++)
            for (int w = 0; w <= p + 1; w++)
              run_config(ctr[0], inv[0], dm != 0, (dm == 2) ? 3 : 1, p, w);

    // R9: mid-cycle period write applies after the next cycle end
    reg_wr(3'd1, 8'hFF);
    reg_wr(3'd2, 8'd3);
    reg_wr(3'd3, 8'd2);
    reg_wr(3'd4, 8'd0);
    reg_wr(3'd0, 8'h01);
    @(negedge clk);
    reg_wr(3'd2, 8'd6);
    for (int t = 2; t <= 11; t++) begin
      check("R9 shadow load", int'(cyc_end), int'(t == 3 || t == 10));
      @(negedge clk);
    end

    // R10: freeze keeps the old period while running
    reg_wr(3'd1, 8'hFF);
    reg_wr(3'd2, 8'd3);
    reg_wr(3'd0, 8'h10);
    reg_wr(3'd0, 8'h01);
    @(negedge clk);
    reg_wr(3'd2, 8'd6);
    for (int t = 2; t <= 12; t++) begin
      check("R10 frozen", int'(cyc_end), int'((t % 4) == 3));
      @(negedge clk);
    end

    // R11: halting loads the staged period, even with freeze set
    reg_wr(3'd1, 8'h01);
    reg_wr(3'd0, 8'h01);
    for (int t = 0; t <= 14; t++) begin
      check("R11 halted follow", int'(cyc_end), int'((t % 7) == 6));
      @(negedge clk);
    end

    // R3: stopping mid-run forces passive levels at once
    reg_wr(3'd1, 8'hFF);
    reg_wr(3'd2, 8'd4);
    reg_wr(3'd3, 8'd2);
    reg_wr(3'd0, 8'h04);
    reg_wr(3'd0, 8'h01);
    repeat (3) @(negedge clk);
    reg_wr(3'd1, 8'h01);
    for (int k = 0; k < 5; k++) begin
      check("R3 stop passive", int'({pwm_a, pwm_b, cyc_end}), 'b110);
      @(negedge clk);
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule